// File: doc/BRIEF.md
# DMA Scatter-Gather Address Generator

This block produces the bus addresses for one DMA channel inside a single block transfer. It keeps two independent address engines. The source engine applies gather jumps and the destination engine applies scatter jumps. Each engine advances once for every transfer that the bus side accepts. Between boundaries an engine steps by the transfer width in bytes. After every N accepted transfers it also takes an extra programmable jump, scaled by the same width.

Software-visible configuration arrives as plain inputs. A single start pulse latches the configuration of both sides and loads both start addresses. From then on each side moves only on its own transfer strobe. Each side also pulses a boundary flag on the transfer that completes a group of N. Each engine is a two-state machine. ST_IDLE ignores strobes and moves to ST_RUN on start. ST_RUN reloads on start and otherwise stays in ST_RUN, stepping on each strobe. Only reset returns an engine to ST_IDLE.

Top module: `sg_addr_gen`

## Requirements
- R1: After reset both addresses are 0, both boundary flags are 0 and both engines are in ST_IDLE.
- R2: A start pulse loads each side's start address and latches its mode, width, count, jump and jump-enable. Changes to these inputs while running have no effect until the next start.
- R3: In increment mode (mode code 0), each accepted transfer adds the width in bytes. Width code 0 is 1 byte, code 1 is 2 bytes, code 2 is 4 bytes, and any other code counts as 4 bytes.
- R4: In decrement mode (mode code 1), each accepted transfer subtracts the width in bytes.
- R5: In fixed mode (mode code 2 or 3), the address never moves. The boundary jump and the boundary flag stay off even when jump-enable is 1.
- R6: With the jump active, every count-th accepted transfer after start moves the address by the step plus jump times the width in bytes, in the mode's direction. The transfer counter then restarts, and a new start also restarts it.
- R7: A count of 0 or a jump-enable of 0 disables the boundary jump and the boundary flag, leaving plain stepping.
- R8: The boundary flag is high for exactly the one cycle after the clock edge that accepted the boundary transfer.
- R9: The source strobe moves only the source address and the destination strobe moves only the destination address.
- R10: Strobes before the first start are ignored. When a strobe coincides with start, the start wins and the address equals the start address.
- R11: Address arithmetic wraps modulo 2 to the power of the address width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Loads both sides and restarts their counters |
| src_start_addr_i | input | AW | Source start address |
| src_mode_i | input | 2 | Source mode: 0 increment, 1 decrement, 2/3 fixed |
| src_width_i | input | 3 | Source width code (0=1B, 1=2B, else 4B) |
| src_count_i | input | CW | Source transfers per gather group (0 disables) |
| src_jump_i | input | JW | Source gather jump in width units |
| src_jump_en_i | input | 1 | Source gather enable |
| dst_start_addr_i | input | AW | Destination start address |
| dst_mode_i | input | 2 | Destination mode, same coding as source |
| dst_width_i | input | 3 | Destination width code |
| dst_count_i | input | CW | Destination transfers per scatter group (0 disables) |
| dst_jump_i | input | JW | Destination scatter jump in width units |
| dst_jump_en_i | input | 1 | Destination scatter enable |
| src_xfer_i | input | 1 | Source transfer accepted |
| dst_xfer_i | input | 1 | Destination transfer accepted |
| src_addr_o | output | AW | Current source address |
| dst_addr_o | output | AW | Current destination address |
| src_bnd_o | output | 1 | Source gather boundary pulse |
| dst_bnd_o | output | 1 | Destination scatter boundary pulse |

## Verification
Every result sits one register stage from its cause. A start or a strobe sampled at one rising edge shows its new address and boundary flag directly after that edge, and the flag falls again after the next edge. The bench drives inputs on falling edges and samples one time unit after the rising edge that takes them in. After each strobe it also samples one cycle later to confirm that the flag has dropped. The expected addresses in the vector table are worked out by hand from the step and jump rules.

// File: rtl/sg_pkg.sv
package sg_pkg;

    typedef enum logic [1:0] {
        MODE_INC   = 2'd0,
        MODE_DEC   = 2'd1,
        MODE_FIX   = 2'd2,
        MODE_FIX_B = 2'd3
    } addr_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } side_state_e;

    // width code -> log2 of bytes per transfer; unknown codes use the widest
    function automatic logic [1:0] width_shift(input logic [2:0] code);
        case (code)
            3'd0:    return 2'd0;
            3'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/sg_step_calc.sv
module sg_step_calc
    import sg_pkg::*;
#(
    parameter int AW = 32,
    parameter int JW = 16
) (
    input  logic [2:0]    width_i,
    input  logic [JW-1:0] jump_i,
    output logic [AW-1:0] step_o,
    output logic [AW-1:0] jump_bytes_o
);

    logic [1:0] shift;

    always_comb begin
        shift        = width_shift(width_i);
        step_o       = AW'(1) << shift;
        jump_bytes_o = AW'(jump_i) << shift;
    end

endmodule

// File: rtl/sg_side.sv
module sg_side
    import sg_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int JW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic [1:0]    mode_i,
    input  logic [2:0]    width_i,
    input  logic [CW-1:0] count_i,
    input  logic [JW-1:0] jump_i,
    input  logic          jump_en_i,
    input  logic          xfer_i,
    output logic [AW-1:0] addr_o,
    output logic          bnd_o
);

    side_state_e   state_q, state_d;
    addr_mode_e    mode_q;
    logic [2:0]    width_q;
    logic [CW-1:0] lim_q;
    logic [JW-1:0] jump_q;
    logic          en_q;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] addr_q;
    logic          bnd_q;

    logic [AW-1:0] step, jump_bytes, delta, addr_next;
    logic          jump_live, hit;

    sg_step_calc #(.AW(AW), .JW(JW)) u_step (
        .width_i      (width_q),
        .jump_i       (jump_q),
        .step_o       (step),
        .jump_bytes_o (jump_bytes)
    );

    // fixed mode forces the boundary jump off whatever the enable says
    assign jump_live = en_q && (mode_q == MODE_INC || mode_q == MODE_DEC) && (lim_q != '0);
    assign hit       = jump_live && (cnt_q == lim_q - CW'(1));
    assign delta     = step + (hit ? jump_bytes : '0);

    always_comb begin
        unique case (mode_q)
            MODE_INC: addr_next = addr_q + delta;
            MODE_DEC: addr_next = addr_q - delta;
            default:  addr_next = addr_q;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mode_q  <= MODE_INC;
            width_q <= '0;
            lim_q   <= '0;
            jump_q  <= '0;
            en_q    <= 1'b0;
            cnt_q   <= '0;
            addr_q  <= '0;
            bnd_q   <= 1'b0;
        end else begin
            bnd_q <= 1'b0;
            if (start_i) begin
                mode_q  <= addr_mode_e'(mode_i);
                width_q <= width_i;
                lim_q   <= count_i;
                jump_q  <= jump_i;
                en_q    <= jump_en_i;
                cnt_q   <= '0;
                addr_q  <= start_addr_i;
            end else begin
                unique case (state_q)
                    ST_IDLE: ;
                    ST_RUN: begin
                        if (xfer_i) begin
                            addr_q <= addr_next;
                            bnd_q  <= hit;
                            if (hit)            cnt_q <= '0;
                            else if (jump_live) cnt_q <= cnt_q + CW'(1);
                        end
                    end
                endcase
            end
        end
    end

    assign addr_o = addr_q;
    assign bnd_o  = bnd_q;

    a_r2_start_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> addr_q == $past(start_addr_i));

    a_r5_fixed_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RUN && (mode_q == MODE_FIX || mode_q == MODE_FIX_B) && !start_i)
        |=> ($stable(addr_q) && !bnd_q));

    a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        jump_live |-> cnt_q < lim_q);

    a_r7_no_flag_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!jump_live && !start_i) |=> !bnd_q);

    a_r8_flag_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(bnd_q) |-> $past(xfer_i && !start_i && state_q == ST_RUN));

    a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE && !start_i) |=> ($stable(addr_q) && !bnd_q));

endmodule

// File: rtl/sg_addr_gen.sv
module sg_addr_gen #(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int JW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [AW-1:0] src_start_addr_i,
    input  logic [1:0]    src_mode_i,
    input  logic [2:0]    src_width_i,
    input  logic [CW-1:0] src_count_i,
    input  logic [JW-1:0] src_jump_i,
    input  logic          src_jump_en_i,
    input  logic [AW-1:0] dst_start_addr_i,
    input  logic [1:0]    dst_mode_i,
    input  logic [2:0]    dst_width_i,
    input  logic [CW-1:0] dst_count_i,
    input  logic [JW-1:0] dst_jump_i,
    input  logic          dst_jump_en_i,
    input  logic          src_xfer_i,
    input  logic          dst_xfer_i,
    output logic [AW-1:0] src_addr_o,
    output logic [AW-1:0] dst_addr_o,
    output logic          src_bnd_o,
    output logic          dst_bnd_o
);

    localparam int NSIDE = 2; // index 0 source (gather), 1 destination (scatter)

    logic [NSIDE-1:0][AW-1:0] s_start, s_addr;
    logic [NSIDE-1:0][1:0]    s_mode;
    logic [NSIDE-1:0][2:0]    s_width;
    logic [NSIDE-1:0][CW-1:0] s_count;
    logic [NSIDE-1:0][JW-1:0] s_jump;
    logic [NSIDE-1:0]         s_en, s_xfer, s_bnd;

    assign s_start = {dst_start_addr_i, src_start_addr_i};
    assign s_mode  = {dst_mode_i, src_mode_i};
    assign s_width = {dst_width_i, src_width_i};
    assign s_count = {dst_count_i, src_count_i};
    assign s_jump  = {dst_jump_i, src_jump_i};
    assign s_en    = {dst_jump_en_i, src_jump_en_i};
    assign s_xfer  = {dst_xfer_i, src_xfer_i};

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        sg_side #(.AW(AW), .CW(CW), .JW(JW)) u_side (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .start_i      (start_i),
            .start_addr_i (s_start[g]),
            .mode_i       (s_mode[g]),
            .width_i      (s_width[g]),
            .count_i      (s_count[g]),
            .jump_i       (s_jump[g]),
            .jump_en_i    (s_en[g]),
            .xfer_i       (s_xfer[g]),
            .addr_o       (s_addr[g]),
            .bnd_o        (s_bnd[g])
        );
    end

    assign src_addr_o = s_addr[0];
    assign dst_addr_o = s_addr[1];
    assign src_bnd_o  = s_bnd[0];
    assign dst_bnd_o  = s_bnd[1];

    // R9: a strobe on one side never moves the other side's address
    a_r9_src_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!start_i && !src_xfer_i) |=> $stable(src_addr_o));
    a_r9_dst_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!start_i && !dst_xfer_i) |=> $stable(dst_addr_o));

endmodule

// File: tb/test_sg_addr_gen.sv
module test_sg_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] s_sa = '0, d_sa = '0;
    logic [1:0]  s_md = '0, d_md = '0;
    logic [2:0]  s_wd = '0, d_wd = '0;
    logic [15:0] s_ct = '0, d_ct = '0;
    logic [15:0] s_jp = '0, d_jp = '0;
    logic        s_en = 1'b0, d_en = 1'b0;
    logic        sx = 1'b0, dx = 1'b0;
    logic [31:0] s_addr, d_addr;
    logic        s_bnd, d_bnd;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    sg_addr_gen i_sg_addr_gen (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .src_start_addr_i(s_sa), .src_mode_i(s_md), .src_width_i(s_wd),
        .src_count_i(s_ct), .src_jump_i(s_jp), .src_jump_en_i(s_en),
        .dst_start_addr_i(d_sa), .dst_mode_i(d_md), .dst_width_i(d_wd),
        .dst_count_i(d_ct), .dst_jump_i(d_jp), .dst_jump_en_i(d_en),
        .src_xfer_i(sx), .dst_xfer_i(dx),
        .src_addr_o(s_addr), .dst_addr_o(d_addr),
        .src_bnd_o(s_bnd), .dst_bnd_o(d_bnd)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [2:0]  wc;
        logic [7:0]  cnt;
        logic [7:0]  jmp;
        logic        en;
        logic [3:0]  n;
        logic [31:0] exp_addr;
        logic [3:0]  exp_flags;
    } vec_t;

    // source side from 0x1000; expected values by hand
    localparam vec_t VECS [10] = '{
        '{2'd0, 3'd0, 8'd0, 8'd0, 1'b0, 4'd3, 32'h0000_1003, 4'd0},
        '{2'd0, 3'd1, 8'd0, 8'd0, 1'b0, 4'd3, 32'h0000_1006, 4'd0},
        '{2'd0, 3'd2, 8'd0, 8'd0, 1'b0, 4'd3, 32'h0000_100C, 4'd0},
        '{2'd0, 3'd3, 8'd0, 8'd0, 1'b0, 4'd2, 32'h0000_1008, 4'd0},
        '{2'd1, 3'd2, 8'd0, 8'd0, 1'b0, 4'd3, 32'h0000_0FF4, 4'd0},
        '{2'd0, 3'd2, 8'd2, 8'd3, 1'b1, 4'd4, 32'h0000_1028, 4'd2},
        '{2'd1, 3'd1, 8'd3, 8'd5, 1'b1, 4'd3, 32'h0000_0FF0, 4'd1},
        '{2'd0, 3'd2, 8'd2, 8'd3, 1'b0, 4'd4, 32'h0000_1010, 4'd0},
        '{2'd2, 3'd2, 8'd1, 8'd7, 1'b1, 4'd3, 32'h0000_1000, 4'd0},
        '{2'd0, 3'd0, 8'd1, 8'd2, 1'b1, 4'd2, 32'h0000_1006, 4'd2}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // one accepted transfer; returns the flag seen after the accepting edge
    task automatic do_xfer(input bit dst, output logic flag);
        @(negedge clk);
        if (dst) dx = 1'b1; else sx = 1'b1;
        @(posedge clk); #1;
        flag = dst ? d_bnd : s_bnd;
        @(negedge clk); sx = 1'b0; dx = 1'b0;
        @(posedge clk); #1;
        chk("R8 flag one cycle", {31'd0, dst ? d_bnd : s_bnd}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R1 watchdog act=timeout exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic f;
        int   nflag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 src addr", s_addr, 32'h0);
        chk("R1 dst addr", d_addr, 32'h0);
        chk("R1 flags", {30'd0, s_bnd, d_bnd}, 32'h0);

        // R10: strobe before any start is ignored
        do_xfer(1'b0, f);
        chk("R10 idle src addr", s_addr, 32'h0);
        chk("R10 idle flag", {31'd0, f}, 32'h0);

        // R10: strobe together with start, start wins
        s_sa = 32'h2000; s_md = 2'd0; s_wd = 3'd2;
        @(negedge clk); start = 1'b1; sx = 1'b1;
        @(negedge clk); start = 1'b0; sx = 1'b0;
        chk("R10 start wins", s_addr, 32'h2000);

        // table walk on the source; destination held as a witness for R9
        d_sa = 32'h8000; d_md = 2'd0; d_wd = 3'd0; d_ct = '0; d_jp = '0; d_en = 1'b0;
        foreach (VECS[i]) begin
            s_sa = 32'h1000; s_md = VECS[i].mode; s_wd = VECS[i].wc;
            s_ct = 16'(VECS[i].cnt); s_jp = 16'(VECS[i].jmp); s_en = VECS[i].en;
            pulse_start();
            chk("R2 load", s_addr, 32'h1000);
            nflag = 0;
            for (int k = 0; k < int'(VECS[i].n); k++) begin
                do_xfer(1'b0, f);
                nflag += int'(f);
            end
            chk("R3 R4 R5 R6 R7 table addr", s_addr, VECS[i].exp_addr);
            chk("R6 R7 R8 table flags", 32'(nflag), 32'(VECS[i].exp_flags));
            chk("R9 dst untouched", d_addr, 32'h8000);
        end

        // R2: config changes after start have no effect
        s_sa = 32'h3000; s_md = 2'd0; s_wd = 3'd2; s_ct = '0; s_en = 1'b0;
        pulse_start();
        s_sa = 32'h5555; s_md = 2'd1; s_wd = 3'd0; s_ct = 16'd1; s_jp = 16'd9; s_en = 1'b1;
        do_xfer(1'b0, f);
        chk("R2 latched config", s_addr, 32'h3004);
        chk("R2 latched no flag", {31'd0, f}, 32'h0);

        // R11: wrap
        s_sa = 32'hFFFF_FFFE; s_md = 2'd0; s_wd = 3'd1; s_ct = '0; s_en = 1'b0;
        pulse_start();
        do_xfer(1'b0, f);
        do_xfer(1'b0, f);
        chk("R11 wrap", s_addr, 32'h0000_0002);

        // R6 R8 R9: destination scatter
        s_sa = 32'h1000; s_md = 2'd0; s_wd = 3'd2; s_ct = '0; s_en = 1'b0;
        d_sa = 32'h4000; d_md = 2'd0; d_wd = 3'd1; d_ct = 16'd2; d_jp = 16'd4; d_en = 1'b1;
        pulse_start();
        do_xfer(1'b1, f);
        chk("R6 dst first", d_addr, 32'h4002);
        chk("R8 dst no flag", {31'd0, f}, 32'h0);
        do_xfer(1'b1, f);
        chk("R6 dst boundary", d_addr, 32'h400C);
        chk("R8 dst flag", {31'd0, f}, 32'h1);
        chk("R9 src untouched", s_addr, 32'h1000);

        // R6: restart reloads the counter
        do_xfer(1'b1, f);
        pulse_start();
        do_xfer(1'b1, f);
        chk("R6 restart count", d_addr, 32'h4002);
        chk("R6 restart no flag", {31'd0, f}, 32'h0);

        // R5: destination fixed via code 3
        d_md = 2'd3; d_ct = 16'd1; d_jp = 16'd7; d_en = 1'b1;
        pulse_start();
        do_xfer(1'b1, f);
        do_xfer(1'b1, f);
        chk("R5 dst fixed", d_addr, 32'h4000);
        chk("R5 dst fixed flag", {31'd0, f}, 32'h0);

        // R4 with scatter on destination
        d_md = 2'd1; d_wd = 3'd2; d_ct = 16'd1; d_jp = 16'd1; d_en = 1'b1;
        pulse_start();
        do_xfer(1'b1, f);
        chk("R4 dst dec jump", d_addr, 32'h3FF8);
        chk("R8 dst dec flag", {31'd0, f}, 32'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule